// File: doc/BRIEF.md
# Shift and Rotate Flag Unit

This block is the combinational shift and rotate datapath of a small processor's execute stage. In one pass it takes a 32-bit operand, a shift count and an operation code. It produces the shifted or rotated result, the next values of the four condition flags, and a write-enable for each flag. The register file applies the result. The flag register uses the enables to decide which of the new flag values it keeps.

The shift count comes from one of two places. It can be the full 32-bit value of a second register, or it can be an 8-bit immediate that is zero-extended. The operations are:

- arithmetic right shift
- logical right shift
- variable left shift
- a fixed left shift by two, which ignores the count
- one-bit rotate right through carry
- one-bit rotate left through carry

Each family follows its own flag rule. The block contains no state machine. It is a fixed pipeline of four parts:

1. amount selection and saturation
2. a shared right barrel shifter, with bit reversal for the left shifts
3. a carry rotator
4. a flag composer that decodes the operation with a unique case

There are no states or transitions.

Top module: `shrot_unit`

## Requirements
- R1: With op_sel = 0 (arithmetic right shift), the result is the operand shifted right by the effective count, and the vacated high bits are filled with operand bit 31.
- R2: With op_sel = 1 (logical right shift), the result is the operand shifted right by the effective count, and the vacated bits are filled with zeros.
- R3: When amt_use_imm is 1, the effective count is amt_imm zero-extended, and amt_reg has no effect. When it is 0, the effective count is all 32 bits of amt_reg.
- R4: An effective count of 32 or more gives all zeros for the logical right shift and the left shift, and 32 copies of operand bit 31 for the arithmetic right shift.
- R5: An effective count of zero returns the operand unchanged for the two right shifts and the left shift. The flag rules still apply.
- R6: For both right shifts, flags_we = 4'b0111. The new C (bit 2) is operand bit 0 whatever the count, and V (bit 3) passes through from flags_in.
- R7: For op_sel = 2 (left shift by count) and op_sel = 3 (left shift by two, count ignored), flags_we = 4'b0011, and C and V pass through unchanged.
- R8: With op_sel = 4 (rotate right), the result is {flags_in[2], operand[31:1]} and the new C is operand bit 0.
- R9: With op_sel = 5 (rotate left), the result is {operand[30:0], flags_in[2]} and the new C is operand bit 31.
- R10: Both rotates set flags_we = 4'b1111 and always drive V (bit 3) to 0.
- R11: Wherever Z (bit 0) is written, it is 1 exactly when the 32-bit result is zero. Wherever N (bit 1) is written, it equals result bit 31.
- R12: op_sel = 6 and 7 are reserved. The result equals the operand, flags_we = 0, and flags_out equals flags_in.
- R13: A flag whose write-enable is 0 is presented on flags_out with its flags_in value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (0 arith right, 1 logical right, 2 left, 3 left by two, 4 rotate right, 5 rotate left, 6/7 reserved) |
| operand | input | 32 | Value to shift or rotate |
| amt_reg | input | 32 | Shift count taken from a register |
| amt_imm | input | 8 | Shift count taken from an immediate |
| amt_use_imm | input | 1 | Selects the immediate count when 1 |
| flags_in | input | 4 | Current flags {V, C, N, Z} |
| result | output | 32 | Shifted or rotated value |
| flags_out | output | 4 | Next flags {V, C, N, Z} |
| flags_we | output | 4 | Per-flag write enable, same bit order |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Register counts whose upper bits are set but whose low five bits are small.** A design that drops the upper bits would shift by the low bits instead of saturating.
- **Counts of exactly 31, 32 and 255.** These catch off-by-one saturation, and a wrong fill on the arithmetic shift of negative values.
- **Right shifts by zero with bit 0 set.** A design that takes C from the last bit shifted out would leave C stale here.
- **Left shifts with C and V preset.** A design that writes C would corrupt these.
- **Rotates with both carry values and a result that becomes zero.** These expose a swapped carry path and a V left uncleared.
- **The fixed left shift given a conflicting count, and an immediate count given a conflicting register value.** These show whether an input that should be ignored leaks into the result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ASR  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASL  = 3'd2,
        OP_ASL2 = 3'd3,
        OP_ROR  = 3'd4,
        OP_ROL  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } shrot_op_e;

    localparam int FLAG_Z = 0;
    localparam int FLAG_N = 1;
    localparam int FLAG_C = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        FAM_RIGHT = 2'd0,
        FAM_LEFT  = 2'd1,
        FAM_ROT   = 2'd2,
        FAM_NONE  = 2'd3
    } shrot_fam_e;

    function automatic shrot_fam_e op_family(input shrot_op_e op);
        shrot_fam_e f;
        unique case (op)
            OP_ASR, OP_LSR:  f = FAM_RIGHT;
            OP_ASL, OP_ASL2: f = FAM_LEFT;
            OP_ROR, OP_ROL:  f = FAM_ROT;
            default:         f = FAM_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/shrot_amount.sv
module shrot_amount #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 32,
    parameter int IMM_W = 8,
    parameter int FIXED_AMT = 2
) (
    input  logic [AMT_W-1:0]         amt_reg,
    input  logic [IMM_W-1:0]         amt_imm,
    input  logic                     use_imm,
    input  logic                     force_fixed,
    output logic [$clog2(WIDTH)-1:0] stage_amt,
    output logic                     saturate
);
    localparam int SH_W = $clog2(WIDTH);

    logic [AMT_W-1:0] picked;

    always_comb begin
        if (use_imm) begin
            picked = {{(AMT_W-IMM_W){1'b0}}, amt_imm};
        end else begin
            picked = amt_reg;
        end
    end

    always_comb begin
        if (force_fixed) begin
            stage_amt = SH_W'(FIXED_AMT);
            saturate  = 1'b0;
        end else begin
            stage_amt = picked[SH_W-1:0];
            saturate  = |picked[AMT_W-1:SH_W];
        end
    end

endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         din,
    input  logic [$clog2(WIDTH)-1:0] amt,
    input  logic                     saturate,
    input  logic                     fill,
    output logic [WIDTH-1:0]         dout
);
    localparam int SH_W = $clog2(WIDTH);

    logic [WIDTH-1:0] stage [0:SH_W];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
                                   : stage[k];
    end

    assign dout = saturate ? {WIDTH{fill}} : stage[SH_W];

endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic             carry_in,
    input  logic             go_left,
    output logic [WIDTH-1:0] dout,
    output logic             carry_out
);
    always_comb begin
        if (go_left) begin
            dout      = {din[WIDTH-2:0], carry_in};
            carry_out = din[WIDTH-1];
        end else begin
            dout      = {carry_in, din[WIDTH-1:1]};
            carry_out = din[0];
        end
    end

endmodule

// File: rtl/shrot_flagger.sv
module shrot_flagger
    import shrot_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  shrot_op_e         op,
    input  logic [WIDTH-1:0]  res,
    input  logic              carry_new,
    input  logic [FLAG_W-1:0] fin,
    output logic [FLAG_W-1:0] fout,
    output logic [FLAG_W-1:0] fwe
);
    logic z_val;
    logic n_val;

    assign z_val = (res == '0);
    assign n_val = res[WIDTH-1];

    always_comb begin
        fout = fin;
        fwe  = '0;
        unique case (op)
            OP_ASR, OP_LSR: begin
                fwe[FLAG_Z]  = 1'b1;
                fwe[FLAG_N]  = 1'b1;
                fwe[FLAG_C]  = 1'b1;
                fout[FLAG_Z] = z_val;
                fout[FLAG_N] = n_val;
                fout[FLAG_C] = carry_new;
            end
            OP_ASL, OP_ASL2: begin
                fwe[FLAG_Z]  = 1'b1;
                fwe[FLAG_N]  = 1'b1;
                fout[FLAG_Z] = z_val;
                fout[FLAG_N] = n_val;
            end
            OP_ROR, OP_ROL: begin
                fwe          = '1;
                fout[FLAG_Z] = z_val;
                fout[FLAG_N] = n_val;
                fout[FLAG_C] = carry_new;
                fout[FLAG_V] = 1'b0;
            end
            default: begin
                fwe  = '0;
                fout = fin;
            end
        endcase
    end

    always_comb begin
        for (int b = 0; b < FLAG_W; b++) begin
            if (!fwe[b]) begin
                assert_hold_unwritten_R13: assert (fout[b] == fin[b])
                    else $error("unwritten flag %0d changed", b);
            end
        end
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 32,
    parameter int IMM_W = 8
) (
    input  logic [2:0]        op_sel,
    input  logic [WIDTH-1:0]  operand,
    input  logic [AMT_W-1:0]  amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic              amt_use_imm,
    input  logic [3:0]        flags_in,
    output logic [WIDTH-1:0]  result,
    output logic [3:0]        flags_out,
    output logic [3:0]        flags_we
);
    localparam int SH_W = $clog2(WIDTH);

    shrot_op_e  op;
    shrot_fam_e fam;

    assign op  = shrot_op_e'(op_sel);
    assign fam = op_family(op);

    logic [SH_W-1:0]  stage_amt;
    logic             saturate;
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] shift_in;
    logic [WIDTH-1:0] shift_out;
    logic [WIDTH-1:0] rev_out;
    logic             fill_bit;
    logic [WIDTH-1:0] rot_out;
    logic             rot_carry;
    logic             carry_new;

    shrot_amount #(
        .WIDTH(WIDTH), .AMT_W(AMT_W), .IMM_W(IMM_W), .FIXED_AMT(2)
    ) u_amount (
        .amt_reg     (amt_reg),
        .amt_imm     (amt_imm),
        .use_imm     (amt_use_imm),
        .force_fixed (op == OP_ASL2),
        .stage_amt   (stage_amt),
        .saturate    (saturate)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_in[i]  = operand[WIDTH-1-i];
        assign rev_out[i] = shift_out[WIDTH-1-i];
    end

    assign shift_in = (fam == FAM_LEFT) ? rev_in : operand;
    assign fill_bit = (op == OP_ASR) ? operand[WIDTH-1] : 1'b0;

    shrot_barrel #(.WIDTH(WIDTH)) u_barrel (
        .din      (shift_in),
        .amt      (stage_amt),
        .saturate (saturate),
        .fill     (fill_bit),
        .dout     (shift_out)
    );

    shrot_rotator #(.WIDTH(WIDTH)) u_rot (
        .din       (operand),
        .carry_in  (flags_in[FLAG_C]),
        .go_left   (op == OP_ROL),
        .dout      (rot_out),
        .carry_out (rot_carry)
    );

    always_comb begin
        unique case (fam)
            FAM_RIGHT: begin
                result    = shift_out;
                carry_new = operand[0];
            end
            FAM_LEFT: begin
                result    = rev_out;
                carry_new = 1'b0;
            end
            FAM_ROT: begin
                result    = rot_out;
                carry_new = rot_carry;
            end
            default: begin
                result    = operand;
                carry_new = 1'b0;
            end
        endcase
    end

    shrot_flagger #(.WIDTH(WIDTH)) u_flags (
        .op        (op),
        .res       (result),
        .carry_new (carry_new),
        .fin       (flags_in),
        .fout      (flags_out),
        .fwe       (flags_we)
    );

    always_comb begin
        if (fam == FAM_RIGHT) begin
            assert_right_carry_R6: assert (flags_out[FLAG_C] == operand[0] && !flags_we[FLAG_V])
                else $error("right shift carry rule broken");
            if (saturate) begin
                assert_sat_fill_R4: assert (result == {WIDTH{fill_bit}})
                    else $error("saturated shift not filled");
            end
            if (!saturate && stage_amt == '0) begin
                assert_zero_amt_R5: assert (result == operand)
                    else $error("zero count altered operand");
            end
        end
        if (fam == FAM_LEFT) begin
            assert_left_keep_cv_R7: assert (flags_out[FLAG_C] == flags_in[FLAG_C]
                                         && flags_out[FLAG_V] == flags_in[FLAG_V]
                                         && flags_we == 4'b0011)
                else $error("left shift touched C or V");
        end
        if (fam == FAM_ROT) begin
            assert_rot_clear_v_R10: assert (flags_out[FLAG_V] == 1'b0 && flags_we[FLAG_V])
                else $error("rotate did not clear V");
        end
        if (fam == FAM_NONE) begin
            assert_reserved_idle_R12: assert (flags_we == '0 && result == operand)
                else $error("reserved op had an effect");
        end
    end

endmodule

// File: tb/sim_shrot_unit.sv
`timescale 1ns/1ps
module sim_shrot_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [2:0]  op_sel;
    logic [31:0] operand;
    logic [31:0] amt_reg;
    logic [7:0]  amt_imm;
    logic        amt_use_imm;
    logic [3:0]  flags_in;
    logic [31:0] result;
    logic [3:0]  flags_out;
    logic [3:0]  flags_we;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    shrot_unit u0 (
        .op_sel      (op_sel),
        .operand     (operand),
        .amt_reg     (amt_reg),
        .amt_imm     (amt_imm),
        .amt_use_imm (amt_use_imm),
        .flags_in    (flags_in),
        .result      (result),
        .flags_out   (flags_out),
        .flags_we    (flags_we)
    );

    // Reference built from the requirement text; flag order {V,C,N,Z}.
    function automatic void model(input logic [2:0] op, input logic [31:0] x,
                                  input logic [31:0] amt, input logic [3:0] fin,
                                  output logic [31:0] r, output logic [3:0] fo,
                                  output logic [3:0] we);
        logic c;
        c = 1'b0;
        case (op)
            3'd0: begin // R1 R4 R6
                r  = (amt >= 32) ? {32{x[31]}} : 32'($signed(x) >>> amt[4:0]);
                c  = x[0];
                we = 4'b0111;
            end
            3'd1: begin // R2 R4 R6
                r  = x >> amt;
                c  = x[0];
                we = 4'b0111;
            end
            3'd2: begin r = x << amt; we = 4'b0011; end // R7
            3'd3: begin r = x << 2;   we = 4'b0011; end // R7
            3'd4: begin r = {fin[2], x[31:1]}; c = x[0];  we = 4'b1111; end // R8
            3'd5: begin r = {x[30:0], fin[2]}; c = x[31]; we = 4'b1111; end // R9
            default: begin r = x; we = 4'b0000; end // R12
        endcase
        fo = fin; // R13
        if (we[0]) fo[0] = (r == 32'd0); // R11
        if (we[1]) fo[1] = r[31];        // R11
        if (we[2]) fo[2] = c;
        if (we[3]) fo[3] = 1'b0;         // R10
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1 R6";
            3'd1: return "R2 R6";
            3'd2, 3'd3: return "R7";
            3'd4: return "R8 R10";
            3'd5: return "R9 R10";
            default: return "R12";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input logic [31:0] x,
                         input logic [31:0] areg, input logic [7:0] aimm,
                         input logic usei, input logic [3:0] fin, input string tag);
        logic [31:0] er;
        logic [3:0]  ef;
        logic [3:0]  ew;
        @(negedge clk);
        op_sel = op; operand = x; amt_reg = areg; amt_imm = aimm;
        amt_use_imm = usei; flags_in = fin;
        #1;
        model(op, x, usei ? {24'd0, aimm} : areg, fin, er, ef, ew);
        vectors++;
        if (result !== er || flags_out !== ef || flags_we !== ew) begin
            misses++;
            $display("FAIL %s op=%0d x=%h: got result=%h flags=%b we=%b, expected result=%h flags=%b we=%b",
                     tag, op, x, result, flags_out, flags_we, er, ef, ew);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        op_sel = 0; operand = 0; amt_reg = 0; amt_imm = 0; amt_use_imm = 0; flags_in = 0;
        repeat (4) @(posedge clk);
        rst = 1'b0;

        // Idle inputs: zero result sets Z (R11)
        apply(3'd0, 32'h0, 32'h0, 8'h0, 1'b0, 4'b0000, "R11 idle");
        // Saturation edges (R4)
        apply(3'd0, 32'h8000_1234, 32'd31, 8'h0, 1'b0, 4'b1000, "R4 asr31");
        apply(3'd0, 32'h8000_1234, 32'd32, 8'h0, 1'b0, 4'b1000, "R4 asr32");
        apply(3'd1, 32'hFFFF_FFFF, 32'd32, 8'h0, 1'b0, 4'b0000, "R4 lsr32");
        apply(3'd2, 32'hFFFF_FFFF, 32'h0001_0001, 8'h0, 1'b0, 4'b1100, "R4 asl high bits");
        apply(3'd0, 32'h9000_0000, 32'h0, 8'hFF, 1'b1, 4'b0000, "R4 R3 imm255");
        // Zero count keeps operand, carry from bit 0 (R5 R6)
        apply(3'd1, 32'h8000_0001, 32'd0, 8'h0, 1'b0, 4'b1000, "R5 R6 lsr0");
        apply(3'd2, 32'h0000_0000, 32'd0, 8'h0, 1'b0, 4'b1100, "R5 R7 asl0");
        // Ignored inputs (R3 R7)
        apply(3'd1, 32'hF0F0_F0F0, 32'd40, 8'd4, 1'b1, 4'b0000, "R3 imm wins");
        apply(3'd3, 32'h4000_0001, 32'd17, 8'd9, 1'b0, 4'b1100, "R7 fixed two");
        // Rotates with both carries (R8 R9 R10)
        apply(3'd4, 32'h0000_0001, 32'd0, 8'h0, 1'b0, 4'b1000, "R8 R10 to zero");
        apply(3'd4, 32'h0000_0002, 32'd0, 8'h0, 1'b0, 4'b1100, "R8 carry in");
        apply(3'd5, 32'h8000_0000, 32'd0, 8'h0, 1'b0, 4'b1000, "R9 R10 to zero");
        apply(3'd5, 32'h4000_0000, 32'd0, 8'h0, 1'b0, 4'b0100, "R9 carry in");
        // Reserved codes (R12 R13)
        apply(3'd6, 32'h1234_5678, 32'd3, 8'd3, 1'b0, 4'b1010, "R12 R13 op6");
        apply(3'd7, 32'h0, 32'd3, 8'd3, 1'b1, 4'b0101, "R12 R13 op7");

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  op;
            logic [31:0] areg;
            op   = 3'($urandom % 8);
            areg = ($urandom % 3 == 0) ? $urandom : ($urandom % 40);
            apply(op, $urandom, areg, 8'($urandom), 1'($urandom), 4'($urandom), op_tag(op));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule